// File: doc/BRIEF.md
# Multi-Size Cipher Key Expansion Sequencer

This block turns a 128-, 192- or 256-bit cipher key into four 32-bit whitening words and a stream of 32-bit round keys. When a key is accepted, the block derives a left key half and a right key half from it. The whitening value is the XOR of the two halves. For a 128-bit key the right half is zero, so the whitening value is the key itself.

The caller runs the Feistel pass over the key elsewhere. At the start pulse the caller presents the one or two 128-bit intermediate blocks from that pass. The sequencer then walks through groups of four round keys. Each word comes from the active intermediate block, XORed with a per-index constant and, on selected groups, with a key half. Between groups a fixed 128-bit double-swap permutation moves the intermediate blocks forward.

Round keys leave one word per cycle on a valid/ready port, and the final word is flagged. The four base constants are a parameter.

Top module: `ckx_keyexp`

## Requirements
- R1: After reset `busy_o` and `rk_valid_o` are 0.
- R2: A start with `size_i`=0 (128-bit) makes `wk_o` equal `key_i[255:128]` from the next cycle on.
- R3: With `size_i`=1 (192-bit) the key words are K0..K5 = `key_i[255:224]` down to `key_i[95:64]`. The left half is K0..K3 and the right half is K4, K5, ~K0, ~K1. `wk_o` is left XOR right, with the first-listed word in the top 32 bits.
- R4: With `size_i`=2 (256-bit) the left half is `key_i[255:128]`, the right half is `key_i[127:0]`, and `wk_o` is their XOR.
- R5: The double-swap maps a 128-bit x to {x[120:64], x[6:0], x[127:121], x[63:7]}.
- R6: A 128-, 192- or 256-bit run emits exactly 36, 44 or 52 words. `rk_last_o` is 1 on the final word only, and `busy_o` falls in the cycle after that word is taken.
- R7: 128-bit word i, with group g=i/4 and lane j=i%4, is lane j of T XOR con(i) XOR (lane j of the left half when g is odd). Lane 0 is bits [127:96]. T starts as `lfirst_i` and is double-swapped after every group.
- R8: 192/256-bit word i, with phase p=g%4, takes its lane from A (`lfirst_i`) when p<2 and from B (`lsecond_i`) otherwise. It is XORed with con(i), with the left half when p=1, and with the right half when p=3. A is double-swapped after phase-1 groups and B after phase-3 groups.
- R9: While `rk_valid_o` is 1 and `rk_ready_i` is 0, the next cycle keeps `rk_valid_o` at 1 and `rk_data_o` unchanged.
- R10: A start pulse while `busy_o` is 1 is ignored: the stream and `wk_o` continue unchanged.
- R11: A start with the reserved `size_i`=3 is ignored and `busy_o` stays 0.
- R12: con(i) = CON_TAB[i%4] XOR {4 copies of the 8-bit index i}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a key when idle |
| size_i | input | 2 | Key size: 0=128, 1=192, 2=256, 3 reserved |
| key_i | input | 256 | Key, first word in the top bits |
| lfirst_i | input | 128 | Intermediate block L (or LL) |
| lsecond_i | input | 128 | Intermediate block LR (unused for 128-bit keys) |
| busy_o | output | 1 | A run is in progress |
| wk_o | output | 128 | Whitening words |
| rk_valid_o | output | 1 | Round-key word valid |
| rk_ready_i | input | 1 | Consumer takes the word |
| rk_data_o | output | 32 | Round-key word |
| rk_last_o | output | 1 | Final word of the run |

## Verification
A start sampled on one edge sets `busy_o` and `wk_o` by the next edge, and word 0 is presented in that same cycle. Each later word appears one cycle after a handshake, and `busy_o` clears one cycle after the flagged word is taken. The bench drives inputs just after the rising edge and checks status at the falling edge of the following cycle. The monitor samples words at falling edges, where a handshake is decided for the edge that follows. The monitor compares each word against a queue filled from the requirements, under always-ready, alternating and pseudo-random ready patterns.

// File: rtl/ckx_pkg.sv
package ckx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BLK_W  = 4 * WORD_W;
    localparam int unsigned KEY_W  = 2 * BLK_W;
    localparam int unsigned IDX_W  = 6;

    typedef enum logic [1:0] {
        KSZ_128 = 2'd0,
        KSZ_192 = 2'd1,
        KSZ_256 = 2'd2,
        KSZ_RSV = 2'd3
    } ksz_e;

    // double swap of a 128-bit block
    function automatic logic [BLK_W-1:0] dswap(input logic [BLK_W-1:0] x);
        return {x[120:64], x[6:0], x[127:121], x[63:7]};
    endfunction

    function automatic logic [IDX_W-1:0] rk_count(input ksz_e s);
        case (s)
            KSZ_128: return IDX_W'(36);
            KSZ_192: return IDX_W'(44);
            default: return IDX_W'(52);
        endcase
    endfunction
endpackage

// File: rtl/ckx_keyform.sv
module ckx_keyform
    import ckx_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    input  ksz_e             size_i,
    output logic [BLK_W-1:0] kl_o,
    output logic [BLK_W-1:0] kr_o
);
    always_comb begin
        kl_o = key_i[KEY_W-1 -: BLK_W];
        case (size_i)
            KSZ_192: kr_o = {key_i[127:64], ~key_i[255:224], ~key_i[223:192]};
            KSZ_256: kr_o = key_i[BLK_W-1:0];
            default: kr_o = '0;
        endcase
    end
endmodule

// File: rtl/ckx_cnt.sv
module ckx_cnt #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic [IDX_W-1:0] total_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.idx = '0;
        end else if (adv_i) begin
            cnt_d.idx = cnt_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign idx_o  = cnt_q.idx;
    assign last_o = (cnt_q.idx == total_i - IDX_W'(1));
endmodule

// File: rtl/ckx_wordgen.sv
module ckx_wordgen
    import ckx_pkg::*;
#(
    parameter logic [3:0][WORD_W-1:0] CON_TAB = '0
) (
    input  ksz_e              size_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BLK_W-1:0]  kl_i,
    input  logic [BLK_W-1:0]  kr_i,
    input  logic [BLK_W-1:0]  la_i,
    input  logic [BLK_W-1:0]  lb_i,
    output logic [WORD_W-1:0] word_o
);
    logic [1:0]        lane;
    logic [1:0]        phase;
    logic [6:0]        base;
    logic [BLK_W-1:0]  src;
    logic [BLK_W-1:0]  kterm;
    logic [7:0]        idx8;
    logic [WORD_W-1:0] con;

    always_comb begin
        lane  = idx_i[1:0];
        phase = idx_i[3:2];
        base  = {~lane, 5'b0};
        idx8  = 8'(idx_i);
        con   = CON_TAB[lane] ^ {4{idx8}};
        if (size_i == KSZ_128) begin
            src   = la_i;
            kterm = idx_i[2] ? kl_i : '0;
        end else begin
            src = phase[1] ? lb_i : la_i;
            case (phase)
                2'd1:    kterm = kl_i;
                2'd3:    kterm = kr_i;
                default: kterm = '0;
            endcase
        end
        word_o = src[base +: WORD_W] ^ kterm[base +: WORD_W] ^ con;
    end
endmodule

// File: rtl/ckx_keyexp.sv
module ckx_keyexp
    import ckx_pkg::*;
#(
    parameter logic [3:0][WORD_W-1:0] CON_TAB = {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [BLK_W-1:0]  lfirst_i,
    input  logic [BLK_W-1:0]  lsecond_i,
    output logic              busy_o,
    output logic [BLK_W-1:0]  wk_o,
    output logic              rk_valid_o,
    input  logic              rk_ready_i,
    output logic [WORD_W-1:0] rk_data_o,
    output logic              rk_last_o
);
    typedef struct packed {
        logic             busy;
        ksz_e             sz;
        logic [BLK_W-1:0] kl;
        logic [BLK_W-1:0] kr;
        logic [BLK_W-1:0] la;
        logic [BLK_W-1:0] lb;
    } st_s;

    st_s st_d, st_q;

    ksz_e             size_in;
    logic [BLK_W-1:0] kl_new, kr_new;
    logic             accept, hs, grp_end, last;
    logic [IDX_W-1:0] idx;

    assign size_in = ksz_e'(size_i);
    assign accept  = start_i && !st_q.busy && (size_in != KSZ_RSV);
    assign hs      = st_q.busy && rk_ready_i;
    assign grp_end = hs && (idx[1:0] == 2'd3);

    ckx_keyform i_keyform (
        .key_i  (key_i),
        .size_i (size_in),
        .kl_o   (kl_new),
        .kr_o   (kr_new)
    );

    ckx_cnt #(.IDX_W(IDX_W)) i_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (accept),
        .adv_i   (hs),
        .total_i (rk_count(st_q.sz)),
        .idx_o   (idx),
        .last_o  (last)
    );

    ckx_wordgen #(.CON_TAB(CON_TAB)) i_wordgen (
        .size_i (st_q.sz),
        .idx_i  (idx),
        .kl_i   (st_q.kl),
        .kr_i   (st_q.kr),
        .la_i   (st_q.la),
        .lb_i   (st_q.lb),
        .word_o (rk_data_o)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.sz   = size_in;
            st_d.kl   = kl_new;
            st_d.kr   = kr_new;
            st_d.la   = lfirst_i;
            st_d.lb   = (size_in == KSZ_128) ? '0 : lsecond_i;
        end else if (hs) begin
            if (last) st_d.busy = 1'b0;
            if (grp_end) begin
                if (st_q.sz == KSZ_128) begin
                    st_d.la = dswap(st_q.la);
                end else if (idx[3:2] == 2'd1) begin
                    st_d.la = dswap(st_q.la);
                end else if (idx[3:2] == 2'd3) begin
                    st_d.lb = dswap(st_q.lb);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o     = st_q.busy;
    assign rk_valid_o = st_q.busy;
    assign rk_last_o  = st_q.busy && last;
    assign wk_o       = st_q.kl ^ st_q.kr;

    // R9: a stalled word is held
    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rk_valid_o && !rk_ready_i) |=> (rk_valid_o && $stable(rk_data_o)));

    // R6: last flag only on a presented word, index inside the run
    assert_last_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rk_last_o |-> rk_valid_o);
    assert_idx_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (idx < rk_count(st_q.sz)));

    // R10: a run keeps its key state until its last word is taken
    assert_busy_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(rk_ready_i && rk_last_o)) |=> (busy_o && $stable(wk_o)));

    // R11: reserved size never starts a run
    assert_reserved_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && size_i == 2'd3) |=> !busy_o);

    // R2: 128-bit whitening is the key itself
    assert_wk128_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i && size_i == 2'd0) |=> (wk_o == $past(key_i[255:128])));
endmodule

// File: tb/test_ckx_keyexp.sv
`timescale 1ns/1ps
module test_ckx_keyexp;
    localparam logic [3:0][31:0] CT = {32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4, 32'hC3D2E1F0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   size = 2'd0;
    logic [255:0] key = '0;
    logic [127:0] la = '0, lb = '0;
    logic         busy, rk_valid, rk_last;
    logic         rk_ready = 1'b0;
    logic [127:0] wk;
    logic [31:0]  rk_data;

    always #2 clk = ~clk;

    ckx_keyexp #(.CON_TAB(CT)) i_ckx_keyexp (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .key_i(key),
        .lfirst_i(la), .lsecond_i(lb), .busy_o(busy), .wk_o(wk),
        .rk_valid_o(rk_valid), .rk_ready_i(rk_ready), .rk_data_o(rk_data),
        .rk_last_o(rk_last)
    );

    int n_chk = 0, n_fail = 0, n_got = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    logic [32:0] expq[$];
    string       tagq[$];
    bit          stall_prev = 0;
    logic [31:0] data_prev;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_swap(input logic [127:0] x);
        logic [127:0] y;
        int src;
        for (int o = 0; o < 128; o++) begin
            if (o < 57)       src = o + 7;
            else if (o < 64)  src = o + 64;
            else if (o < 71)  src = o - 64;
            else              src = o - 7;
            y[127 - o] = x[127 - src];
        end
        return y;
    endfunction

    function automatic logic [31:0] ref_con(input int i);
        logic [7:0] b;
        b = 8'(i);
        return CT[i % 4] ^ {b, b, b, b};
    endfunction

    task automatic push_ref(input int sz, input logic [127:0] kl, input logic [127:0] kr,
                            input logic [127:0] a, input logic [127:0] b);
        int n, g, j, p;
        logic [127:0] t1, t2, src, kt;
        logic [31:0] w;
        n = (sz == 0) ? 36 : (sz == 1) ? 44 : 52;
        t1 = a; t2 = b;
        for (int i = 0; i < n; i++) begin
            g = i / 4; j = i % 4; p = g % 4;
            if (sz == 0) begin
                src = t1; kt = (g % 2 == 1) ? kl : '0;
            end else begin
                src = (p < 2) ? t1 : t2;
                kt = (p == 1) ? kl : (p == 3) ? kr : '0;
            end
            w = src[127 - 32*j -: 32] ^ kt[127 - 32*j -: 32] ^ ref_con(i);
            expq.push_back({w, (i == n - 1)});
            tagq.push_back(sz == 0 ? "R7 R5 R12" : "R8 R5 R12");
            if (j == 3) begin
                if (sz == 0)     t1 = ref_swap(t1);
                else if (p == 1) t1 = ref_swap(t1);
                else if (p == 3) t2 = ref_swap(t2);
            end
        end
    endtask

    // monitor: decides ready and pops expected words at falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                chk(rk_valid && rk_data == data_prev, "R9", {96'b0, rk_data}, {96'b0, data_prev});
            case (rdy_mode)
                0: rk_ready = 1'b1;
                1: rk_ready = ~rk_ready;
                default: begin
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                    rk_ready = lfsr[0];
                end
            endcase
            stall_prev = rk_valid && !rk_ready;
            data_prev  = rk_data;
            if (rk_valid && rk_ready) begin
                n_got++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 extra word", {96'b0, rk_data}, '0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(rk_data == e[32:1], t, {96'b0, rk_data}, {96'b0, e[32:1]});
                    chk(rk_last == e[0], "R6 last flag", {127'b0, rk_last}, {127'b0, e[0]});
                end
            end
        end
    end

    task automatic run(input int sz, input logic [255:0] k, input logic [127:0] a,
                       input logic [127:0] b, input int rmode, input bit inject);
        logic [127:0] kl, kr;
        int n;
        string tg;
        kl = k[255:128];
        if (sz == 0)      kr = '0;
        else if (sz == 1) kr = {k[127:64], ~k[255:224], ~k[223:192]};
        else              kr = k[127:0];
        n = (sz == 0) ? 36 : (sz == 1) ? 44 : 52;
        tg = (sz == 0) ? "R2" : (sz == 1) ? "R3" : "R4";
        rdy_mode = rmode;
        push_ref(sz, kl, kr, a, b);
        n_got = 0;
        @(posedge clk); #1;
        start = 1'b1; size = 2'(sz); key = k; la = a; lb = b;
        @(posedge clk); #1;
        start = 1'b0; key = ~k; la = ~a; lb = ~b;
        @(negedge clk); #1;
        chk(busy == 1'b1, tg, {127'b0, busy}, 128'd1);
        chk(wk == (kl ^ kr), tg, wk, kl ^ kr);
        if (inject) begin
            @(posedge clk); #1;
            start = 1'b1; size = 2'd0; key = {8{32'h5A5AA5A5}};
            @(posedge clk); #1;
            start = 1'b0;
            @(negedge clk); #1;
            chk(wk == (kl ^ kr), "R10 whitening", wk, kl ^ kr);
        end
        while (expq.size() != 0) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        chk(busy == 1'b0 && rk_valid == 1'b0, "R6 end of run", {126'b0, busy, rk_valid}, '0);
        chk(n_got == n, "R6 word count", 128'(n_got), 128'(n));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        chk(busy == 1'b0 && rk_valid == 1'b0, "R1", {126'b0, busy, rk_valid}, '0);
        #9 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(busy == 1'b0 && rk_valid == 1'b0, "R1", {126'b0, busy, rk_valid}, '0);

        // R11: reserved size code
        @(posedge clk); #1;
        start = 1'b1; size = 2'd3; key = {8{32'h12345678}};
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk); #1;
        chk(busy == 1'b0 && rk_valid == 1'b0, "R11", {126'b0, busy, rk_valid}, '0);

        run(0, {128'h00112233445566778899AABBCCDDEEFF, 128'hFFFF0000FFFF0000FFFF0000FFFF0000},
            128'h0123456789ABCDEFFEDCBA9876543210, '0, 0, 0);
        run(1, {192'h0F0E0D0C0B0A09080706050403020100F0E0D0C0B0A09080, 64'hDEADBEEFDEADBEEF},
            128'h13579BDF02468ACE1122334455667788, 128'h8899AABBCCDDEEFF0011223344556677, 1, 0);
        run(2, 256'hA1B2C3D4E5F60718293A4B5C6D7E8F90FEDCBA98765432100F1E2D3C4B5A6978,
            128'hCAFEBABE0BADF00D1234567887654321, 128'h55AA55AA00FF00FF0F0F0F0FF0F0F0F0, 2, 0);
        run(2, 256'h0000000100000002000000030000000400000005000000060000000700000008,
            128'h80000000000000000000000000000001, 128'h00000000FFFFFFFF00000000FFFFFFFF, 1, 1);
        run(0, 256'h0, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, '0, 2, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule